// File: doc/BRIEF.md
# Two-Engine Semaphore Lock Bank

This block holds four hardware semaphores that two processing engines share. In any cycle each engine can issue one request, made of a valid strobe, a one-bit operation (lock or free) and a two-bit semaphore index. The block keeps track of which engine owns each semaphore. An engine never holds more than one semaphore, so a free request carries no index: it releases whatever the requesting engine currently owns.

Each engine has a registered lock-status flag. Its branch logic tests this flag one cycle after it issues a request. A true flag means the engine now holds the semaphore it asked for. The busy bit and owner of every semaphore are also driven out, so the surrounding logic can observe them. When both engines ask for the same free semaphore in the same cycle, the lower-numbered engine wins. All decisions use the ownership state as it stood before the clock edge.

Top module: `semBank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every `semBusy` bit, every `semOwner` field and both `lockStat` bits after that edge.
- R2: A lock request (`reqLock`=1, index in `reqSel` as a plain binary semaphore number) for a free semaphore, from an engine that holds nothing, sets `semBusy[index]`, writes the engine number into `semOwner[index]` (field for semaphore s at bits s*1 +: 1) and sets that engine's `lockStat` at the next edge.
- R3: An engine never owns more than one semaphore. A lock request from an engine that already holds a different semaphore is refused: ownership is unchanged and its `lockStat` is 0.
- R4: A free request (`reqLock`=0) ignores `reqSel`. It releases the semaphore that the requester holds, clearing its busy bit and its owner field, and clears the requester's `lockStat`.
- R5: A free request from an engine that holds nothing leaves all ownership unchanged and clears its `lockStat`.
- R6: A lock request for a semaphore that the requester already owns keeps it owned and sets the requester's `lockStat` to 1.
- R7: A lock request for a semaphore owned by the other engine leaves its ownership unchanged and sets the requester's `lockStat` to 0. This also applies when the owner frees that semaphore in the same cycle.
- R8: If both engines request the same free semaphore in the same cycle and both are eligible, engine 0 gets it with `lockStat[0]`=1, and engine 1 gets `lockStat[1]`=0.
- R9: An engine with `reqValid` low keeps its `lockStat` unchanged, and ownership does not change without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 2 | Per-engine request strobe, bit e for engine e |
| reqLock | input | 2 | Per-engine operation, 1 = lock, 0 = free |
| reqSel | input | 4 | Per-engine semaphore index, bits [2e+1:2e] |
| lockStat | output | 2 | Registered per-engine lock-status flag |
| semBusy | output | 4 | Bit s high while semaphore s is held |
| semOwner | output | 4 | Owning engine of semaphore s at bit s (0 when free) |

## Verification
The assertions assume that `reqLock` and `reqSel` are known whenever `reqValid` is high, and that reset is held for at least one clock edge before requests start. Under those conditions the owner fields stay consistent with the busy bits. The stimulus drives every request field to a defined value on the falling edge and changes inputs only there. It asserts reset before the first vector and again in the middle of a sequence. It also mixes free and lock requests in the same cycle, so the properties about release and contention are reached from both engines.

// File: rtl/semPkg.sv
package semPkg;
  localparam int NUM_ENG = 2;
  localparam int NUM_SEM = 4;
  localparam int ENG_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
  localparam int SEL_W   = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  // Strobes from the control decision to the ownership registers.
  typedef struct packed {
    logic [NUM_SEM-1:0]            grab;
    logic [NUM_SEM-1:0]            drop;
    logic [NUM_SEM-1:0][ENG_W-1:0] newOwner;
    logic [NUM_ENG-1:0]            statLd;
    logic [NUM_ENG-1:0]            statVal;
  } semStb_t;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
(
  input  logic [NUM_ENG-1:0]            reqValid,
  input  logic [NUM_ENG-1:0]            reqLock,
  input  logic [NUM_ENG*SEL_W-1:0]      reqSel,
  input  logic [NUM_SEM-1:0]            busyQ,
  input  logic [NUM_SEM-1:0][ENG_W-1:0] ownerQ,
  output semStb_t                       stb
);
  logic [NUM_SEM-1:0] claimed;
  logic               holds;
  logic [SEL_W-1:0]   heldIdx;
  logic [SEL_W-1:0]   sel;

  always_comb begin
    stb     = '0;
    claimed = '0;
    holds   = 1'b0;
    heldIdx = '0;
    sel     = '0;
    // Lower engine index is evaluated first and so wins contention.
    for (int e = 0; e < NUM_ENG; e++) begin
      holds   = 1'b0;
      heldIdx = '0;
      for (int s = 0; s < NUM_SEM; s++) begin
        if (busyQ[s] && ownerQ[s] == ENG_W'(e)) begin
          holds   = 1'b1;
          heldIdx = SEL_W'(s);
        end
      end
      sel = reqSel[e*SEL_W +: SEL_W];
      if (reqValid[e]) begin
        stb.statLd[e] = 1'b1;
        if (reqLock[e]) begin
          if (busyQ[sel]) begin
            stb.statVal[e] = (ownerQ[sel] == ENG_W'(e));
          end else if (!holds && !claimed[sel]) begin
            stb.grab[sel]     = 1'b1;
            stb.newOwner[sel] = ENG_W'(e);
            claimed[sel]      = 1'b1;
            stb.statVal[e]    = 1'b1;
          end else begin
            stb.statVal[e] = 1'b0;
          end
        end else begin
          if (holds) stb.drop[heldIdx] = 1'b1;
          stb.statVal[e] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/semData.sv
module semData
  import semPkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  semStb_t                       stb,
  output logic [NUM_SEM-1:0]            busyQ,
  output logic [NUM_SEM-1:0][ENG_W-1:0] ownerQ,
  output logic [NUM_ENG-1:0]            statQ
);
  for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
    always_ff @(posedge clk) begin
      if (rst) begin
        busyQ[s]  <= 1'b0;
        ownerQ[s] <= '0;
      end else if (stb.drop[s]) begin
        busyQ[s]  <= 1'b0;
        ownerQ[s] <= '0;
      end else if (stb.grab[s]) begin
        busyQ[s]  <= 1'b1;
        ownerQ[s] <= stb.newOwner[s];
      end
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    always_ff @(posedge clk) begin
      if (rst)               statQ[e] <= 1'b0;
      else if (stb.statLd[e]) statQ[e] <= stb.statVal[e];
    end
  end
endmodule

// File: rtl/semBank.sv
module semBank
  import semPkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_ENG-1:0]       reqValid,
  input  logic [NUM_ENG-1:0]       reqLock,
  input  logic [NUM_ENG*SEL_W-1:0] reqSel,
  output logic [NUM_ENG-1:0]       lockStat,
  output logic [NUM_SEM-1:0]       semBusy,
  output logic [NUM_SEM*ENG_W-1:0] semOwner
);
  semStb_t                       stb;
  logic [NUM_SEM-1:0]            busyQ;
  logic [NUM_SEM-1:0][ENG_W-1:0] ownerQ;

  semCtrl u_ctrl (
    .reqValid (reqValid),
    .reqLock  (reqLock),
    .reqSel   (reqSel),
    .busyQ    (busyQ),
    .ownerQ   (ownerQ),
    .stb      (stb)
  );

  semData u_data (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .busyQ  (busyQ),
    .ownerQ (ownerQ),
    .statQ  (lockStat)
  );

  assign semBusy  = busyQ;
  assign semOwner = ownerQ;
endmodule

// File: rtl/semBankChk.sv
module semBankChk
  import semPkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_ENG-1:0]       reqValid,
  input logic [NUM_ENG-1:0]       reqLock,
  input logic [NUM_ENG*SEL_W-1:0] reqSel,
  input logic [NUM_ENG-1:0]       lockStat,
  input logic [NUM_SEM-1:0]       semBusy,
  input logic [NUM_SEM*ENG_W-1:0] semOwner
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (semBusy == '0 && semOwner == '0 && lockStat == '0));

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_e
    logic [NUM_SEM-1:0] ownedBy;
    logic [SEL_W-1:0]   selE;
    for (genvar s = 0; s < NUM_SEM; s++) begin : g_o
      assign ownedBy[s] = semBusy[s] && semOwner[s*ENG_W +: ENG_W] == ENG_W'(e);
    end
    assign selE = reqSel[e*SEL_W +: SEL_W];

    p_single_hold_r3: assert property (@(posedge clk) disable iff (rst)
      $countones(ownedBy) <= 1);

    p_idle_stat_r9: assert property (@(posedge clk) disable iff (rst)
      !reqValid[e] |=> $stable(lockStat[e]));

    for (genvar s = 0; s < NUM_SEM; s++) begin : g_s
      p_free_release_r4: assert property (@(posedge clk) disable iff (rst)
        (reqValid[e] && !reqLock[e] && ownedBy[s]) |=> (!semBusy[s] && !lockStat[e]));

      p_relock_own_r6: assert property (@(posedge clk) disable iff (rst)
        (reqValid[e] && reqLock[e] && selE == SEL_W'(s) && ownedBy[s])
        |=> (lockStat[e] && semBusy[s] && semOwner[s*ENG_W +: ENG_W] == ENG_W'(e)));

      p_foreign_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (reqValid[e] && reqLock[e] && selE == SEL_W'(s) && semBusy[s] && !ownedBy[s])
        |=> !lockStat[e]);
    end
  end

  p_tie_low_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (reqValid == 2'b11 && reqLock == 2'b11 && reqSel[SEL_W-1:0] == reqSel[2*SEL_W-1:SEL_W]
     && !semBusy[reqSel[SEL_W-1:0]] && !g_e[0].ownedBy && !g_e[1].ownedBy)
    |=> (lockStat == 2'b01));
endmodule

bind semBank semBankChk u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqLock  (reqLock),
  .reqSel   (reqSel),
  .lockStat (lockStat),
  .semBusy  (semBusy),
  .semOwner (semOwner)
);

// File: tb/semBank_tb.sv
module semBank_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] reqValid, reqLock;
  logic [3:0] reqSel;
  logic [1:0] lockStat;
  logic [3:0] semBusy;
  logic [3:0] semOwner;
  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  semBank u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqLock(reqLock),
    .reqSel(reqSel), .lockStat(lockStat), .semBusy(semBusy), .semOwner(semOwner)
  );

  // Stimulus nibble per engine: {valid, lock, sel[1:0]}; byte = {eng1, eng0}.
  localparam int NV = 13;
  localparam logic [7:0] STIM [NV] = '{
    8'h0E, 8'hE0, 8'hDE, 8'h0F, 8'h08, 8'h08, 8'h00,
    8'hB0, 8'hCC, 8'hC8, 8'hFF, 8'hDD, 8'hF0 };
  // Expected {busy[3:0], owner[3:0], stat[1:0]} after the edge.
  localparam logic [9:0] EXPV [NV] = '{
    10'b0100_0000_01, 10'b0100_0000_01, 10'b0110_0010_11, 10'b0110_0010_10,
    10'b0010_0010_10, 10'b0010_0010_10, 10'b0010_0010_10, 10'b0000_0000_00,
    10'b0001_0000_01, 10'b0000_0000_00, 10'b1000_0000_01, 10'b1010_0010_10,
    10'b1010_0010_00 };

  function automatic string rowTag(int i);
    case (i)
      0: return "R2";  1: return "R7";  2: return "R6";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R9";  7: return "R4";
      8: return "R8";  9: return "R7"; 10: return "R8"; 11: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [9:0] got, logic [9:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got busy/owner/stat=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] v);
    reqValid = {v[7], v[3]};
    reqLock  = {v[6], v[2]};
    reqSel   = {v[5:4], v[1:0]};
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    apply(8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 initial", {semBusy, semOwner, lockStat}, 10'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(STIM[i]);
      @(negedge clk);
      check(rowTag(i), {semBusy, semOwner, lockStat}, EXPV[i]);
    end

    // R1: reset from a populated state
    apply(8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid", {semBusy, semOwner, lockStat}, 10'b0);

    // R9: engine 1 locks semaphore 2, then idles; flag and ownership hold
    apply(8'hE0);
    @(negedge clk);
    check("R2 eng1", {semBusy, semOwner, lockStat}, 10'b0100_0100_10);
    apply(8'h00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 hold", {semBusy, semOwner, lockStat}, 10'b0100_0100_10);
    end

    // R4: engine 1 frees with selector naming an unheld semaphore
    apply(8'h80);
    @(negedge clk);
    check("R4 selIgnored", {semBusy, semOwner, lockStat}, 10'b0000_0000_00);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule